// File: doc/BRIEF.md
# On-Screen Display Character Attribute and Color Selector

This block sits in the pixel pipeline of an on-screen display overlay. On every pixel clock it receives the display-memory byte for the current character cell, the two control bytes of the current text row, the window membership of the cell and the raw line and dot counters inside the cell. From these it produces three things: the character code that addresses the glyph store, the glyph line and dot indices, and the foreground color for the current pixel.

The foreground color comes from a palette of four 3-bit RGB entries held in the row's two control bytes. Bit 7 of the display byte picks between the first two entries. A cell that lies inside an enabled background window that has its extra color select set gets a second select bit, and that bit moves the choice to the third and fourth entries. Two flags in the first row control byte double the height and the width of every glyph in the row. The block does this by advancing the glyph line index once every two scan lines and the glyph dot index once every two pixel clocks.

All outputs are registered and appear one pixel clock after their inputs. The glyph bit read from the glyph store is presented with the other inputs, and it gates the foreground flag and the color.

Top module: `osd_attr_sel`

## Requirements
- R1: While `rst` is high, every output is 0 at the clock edge that follows.
- R2: `rom_code` equals bits 6..0 of `disp_byte` from the previous clock edge, whatever the values of the other inputs.
- R3: When the window extra select is inactive, a visible pixel takes the color in `row_ctl_a` bits 7..5 (red, green, blue) if `disp_byte` bit 7 is 0. It takes the color in `row_ctl_a` bits 4..2 if that bit is 1.
- R4: When `win_hit`, `win_en` and `win_xsel` are all 1, a visible pixel takes the color in `row_ctl_b` bits 7..5 if `disp_byte` bit 7 is 0. It takes the color in `row_ctl_b` bits 4..2 if that bit is 1.
- R5: The window extra select is active only when `win_hit`, `win_en` and `win_xsel` are all 1. If any one of them is 0, the color follows R3 and the contents of `row_ctl_b` have no effect.
- R6: When `row_ctl_a` bit 1 is 1, `glyph_row` is `scan_line` divided by two, rounded down. When that bit is 0, `glyph_row` equals `scan_line`. Either way the output lags the input by one clock.
- R7: When `row_ctl_a` bit 0 is 1, `glyph_col` is `dot_cnt` divided by two, rounded down. When that bit is 0, `glyph_col` equals `dot_cnt`. Either way the output lags the input by one clock. The height flag and the width flag act independently of each other.
- R8: `fg_valid` is `pix_valid AND glyph_bit` from the previous clock edge. `fg_rgb` is 0 whenever `fg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_valid | input | 1 | Current pixel lies in the active display area |
| disp_byte | input | 8 | Display-memory byte: bit 7 is the color select, bits 6..0 are the character code |
| row_ctl_a | input | 8 | Row control byte: colors 1 and 2, height flag (bit 1), width flag (bit 0) |
| row_ctl_b | input | 8 | Row control byte: colors 3 and 4 |
| win_hit | input | 1 | Cell lies inside the geometry of a background window |
| win_en | input | 1 | That window is enabled |
| win_xsel | input | 1 | That window's extra color select bit |
| scan_line | input | LINE_W | Raw scan line counter inside the cell |
| dot_cnt | input | DOT_W | Raw dot counter inside the cell |
| glyph_bit | input | 1 | Glyph store bit for the current pixel |
| rom_code | output | 7 | Character code for the glyph store |
| glyph_row | output | LINE_W | Scaled glyph line index |
| glyph_col | output | DOT_W | Scaled glyph dot index |
| fg_rgb | output | 3 | Foreground color {R,G,B}, 0 when not visible |
| fg_valid | output | 1 | Foreground pixel present |

## Verification
Palette widening and glyph scaling both act on the same pixel. A cell inside an active window whose row has both doubling flags set must therefore get a third or fourth palette entry and halved indices in one output cycle. The bench provokes this with directed cells that combine all three, and then with a long stream of unconstrained random cells. Each result is compared against a reference model written from the requirements. The incomplete window conditions (hit without enable, enable without extra select) are placed next to complete ones, which shows that a single missing term switches the pixel back to the first two colors.

// File: rtl/osd_attr_pkg.sv
package osd_attr_pkg;

    localparam int RGB_W = 3;

    typedef logic [RGB_W-1:0] rgb_t;

    // Palette slot, ordered {extra_select, char_select}
    typedef enum logic [1:0] {
        SLOT_C1 = 2'd0,
        SLOT_C2 = 2'd1,
        SLOT_C3 = 2'd2,
        SLOT_C4 = 2'd3
    } pal_slot_e;

    // Row control byte layout; packed order matches bit 7 down to bit 0
    typedef struct packed {
        rgb_t hi_color;   // bits 7..5
        rgb_t lo_color;   // bits 4..2
        logic dbl_h;      // bit 1
        logic dbl_w;      // bit 0
    } row_ctl_t;

    function automatic pal_slot_e make_slot(input logic extra, input logic chr_sel);
        return pal_slot_e'({extra, chr_sel});
    endfunction

    function automatic logic window_extra(input logic hit, input logic en, input logic xsel);
        return hit & en & xsel;
    endfunction

endpackage

// File: rtl/osd_color_sel.sv
module osd_color_sel
    import osd_attr_pkg::*;
(
    input  row_ctl_t  pal_a,
    input  row_ctl_t  pal_b,
    input  logic      chr_sel,
    input  logic      win_hit,
    input  logic      win_en,
    input  logic      win_xsel,
    output pal_slot_e slot,
    output rgb_t      color
);

    logic extra;

    always_comb begin
        extra = window_extra(win_hit, win_en, win_xsel);
        slot  = make_slot(extra, chr_sel);
        unique case (slot)
            SLOT_C1: color = pal_a.hi_color;
            SLOT_C2: color = pal_a.lo_color;
            SLOT_C3: color = pal_b.hi_color;
            SLOT_C4: color = pal_b.lo_color;
            default: color = '0;
        endcase
    end

endmodule

// File: rtl/osd_axis_scale.sv
module osd_axis_scale #(
    parameter int W = 4
) (
    input  logic [W-1:0] raw,
    input  logic         dbl,
    output logic [W-1:0] idx
);

    generate
        if (W > 1) begin : g_wide
            always_comb idx = dbl ? {1'b0, raw[W-1:1]} : raw;
        end else begin : g_narrow
            always_comb idx = dbl ? 1'b0 : raw;
        end
    endgenerate

endmodule

// File: rtl/osd_attr_sel.sv
module osd_attr_sel
    import osd_attr_pkg::*;
#(
    parameter int DISP_W = 8,
    parameter int LINE_W = 5,
    parameter int DOT_W  = 4,
    localparam int CODE_W = DISP_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_valid,
    input  logic [DISP_W-1:0] disp_byte,
    input  logic [7:0]        row_ctl_a,
    input  logic [7:0]        row_ctl_b,
    input  logic              win_hit,
    input  logic              win_en,
    input  logic              win_xsel,
    input  logic [LINE_W-1:0] scan_line,
    input  logic [DOT_W-1:0]  dot_cnt,
    input  logic              glyph_bit,
    output logic [CODE_W-1:0] rom_code,
    output logic [LINE_W-1:0] glyph_row,
    output logic [DOT_W-1:0]  glyph_col,
    output logic [RGB_W-1:0]  fg_rgb,
    output logic              fg_valid
);

    row_ctl_t    ctl_a;
    row_ctl_t    ctl_b;
    pal_slot_e   slot;
    rgb_t        pick_color;
    logic [LINE_W-1:0] row_idx;
    logic [DOT_W-1:0]  col_idx;
    logic        visible;

    assign ctl_a   = row_ctl_t'(row_ctl_a);
    assign ctl_b   = row_ctl_t'(row_ctl_b);
    assign visible = pix_valid & glyph_bit;

    osd_color_sel u_color (
        .pal_a    (ctl_a),
        .pal_b    (ctl_b),
        .chr_sel  (disp_byte[DISP_W-1]),
        .win_hit  (win_hit),
        .win_en   (win_en),
        .win_xsel (win_xsel),
        .slot     (slot),
        .color    (pick_color)
    );

    osd_axis_scale #(.W(LINE_W)) u_line_scale (
        .raw (scan_line),
        .dbl (ctl_a.dbl_h),
        .idx (row_idx)
    );

    osd_axis_scale #(.W(DOT_W)) u_dot_scale (
        .raw (dot_cnt),
        .dbl (ctl_a.dbl_w),
        .idx (col_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_code  <= '0;
            glyph_row <= '0;
            glyph_col <= '0;
            fg_rgb    <= '0;
            fg_valid  <= 1'b0;
        end else begin
            rom_code  <= disp_byte[CODE_W-1:0];
            glyph_row <= row_idx;
            glyph_col <= col_idx;
            fg_rgb    <= visible ? pick_color : '0;
            fg_valid  <= visible;
        end
    end

endmodule

// File: rtl/osd_attr_sel_chk.sv
module osd_attr_sel_chk #(
    parameter int DISP_W = 8,
    parameter int LINE_W = 5,
    parameter int DOT_W  = 4,
    localparam int CODE_W = DISP_W - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              pix_valid,
    input logic [DISP_W-1:0] disp_byte,
    input logic [7:0]        row_ctl_a,
    input logic [LINE_W-1:0] scan_line,
    input logic [DOT_W-1:0]  dot_cnt,
    input logic              glyph_bit,
    input logic [CODE_W-1:0] rom_code,
    input logic [LINE_W-1:0] glyph_row,
    input logic [DOT_W-1:0]  glyph_col,
    input logic [2:0]        fg_rgb,
    input logic              fg_valid
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (rom_code == '0 && glyph_row == '0 && glyph_col == '0 &&
                 fg_rgb == '0 && !fg_valid)); // R1

    AST_CODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rom_code == $past(disp_byte[CODE_W-1:0])); // R2

    AST_LINE_SCALE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> glyph_row == ($past(row_ctl_a[1]) ? ($past(scan_line) >> 1)
                                                   : $past(scan_line))); // R6

    AST_DOT_SCALE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> glyph_col == ($past(row_ctl_a[0]) ? ($past(dot_cnt) >> 1)
                                                   : $past(dot_cnt))); // R7

    AST_FG_GATE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> fg_valid == $past(pix_valid && glyph_bit)); // R8

    AST_DARK_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !fg_valid |-> fg_rgb == '0); // R8

endmodule

bind osd_attr_sel osd_attr_sel_chk #(
    .DISP_W (DISP_W),
    .LINE_W (LINE_W),
    .DOT_W  (DOT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .disp_byte (disp_byte),
    .row_ctl_a (row_ctl_a),
    .scan_line (scan_line),
    .dot_cnt   (dot_cnt),
    .glyph_bit (glyph_bit),
    .rom_code  (rom_code),
    .glyph_row (glyph_row),
    .glyph_col (glyph_col),
    .fg_rgb    (fg_rgb),
    .fg_valid  (fg_valid)
);

// File: tb/tb_osd_attr_sel.sv
module tb_osd_attr_sel;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_W = 5;
    localparam int DOT_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pix_valid = 1'b0;
    logic [7:0]        disp_byte = '0;
    logic [7:0]        row_ctl_a = '0;
    logic [7:0]        row_ctl_b = '0;
    logic              win_hit = 1'b0;
    logic              win_en = 1'b0;
    logic              win_xsel = 1'b0;
    logic [LINE_W-1:0] scan_line = '0;
    logic [DOT_W-1:0]  dot_cnt = '0;
    logic              glyph_bit = 1'b0;
    logic [6:0]        rom_code;
    logic [LINE_W-1:0] glyph_row;
    logic [DOT_W-1:0]  glyph_col;
    logic [2:0]        fg_rgb;
    logic              fg_valid;

    typedef struct {
        logic [6:0]        code;
        logic [LINE_W-1:0] row;
        logic [DOT_W-1:0]  col;
        logic [2:0]        rgb;
        logic              vld;
        string             tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osd_attr_sel #(.LINE_W(LINE_W), .DOT_W(DOT_W)) dut (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .disp_byte(disp_byte),
        .row_ctl_a(row_ctl_a), .row_ctl_b(row_ctl_b), .win_hit(win_hit),
        .win_en(win_en), .win_xsel(win_xsel), .scan_line(scan_line),
        .dot_cnt(dot_cnt), .glyph_bit(glyph_bit), .rom_code(rom_code),
        .glyph_row(glyph_row), .glyph_col(glyph_col), .fg_rgb(fg_rgb),
        .fg_valid(fg_valid)
    );

    // Reference palette choice from R3/R4/R5
    function automatic logic [2:0] ref_color(input logic [7:0] a, input logic [7:0] b,
                                             input logic sel, input logic h,
                                             input logic e, input logic x);
        if (h && e && x) return sel ? b[4:2] : b[7:5];
        return sel ? a[4:2] : a[7:5];
    endfunction

    task automatic drive(input logic pv, input logic [7:0] db, input logic [7:0] ca,
                         input logic [7:0] cb, input logic h, input logic e,
                         input logic x, input logic [LINE_W-1:0] ln,
                         input logic [DOT_W-1:0] dt, input logic gb, input string tag);
        exp_t ex;
        @(negedge clk);
        pix_valid = pv; disp_byte = db; row_ctl_a = ca; row_ctl_b = cb;
        win_hit = h; win_en = e; win_xsel = x; scan_line = ln; dot_cnt = dt;
        glyph_bit = gb;
        ex.code = db[6:0];
        ex.row  = ca[1] ? (ln >> 1) : ln;
        ex.col  = ca[0] ? (dt >> 1) : dt;
        ex.vld  = pv & gb;
        ex.rgb  = (pv & gb) ? ref_color(ca, cb, db[7], h, e, x) : 3'd0;
        ex.tag  = tag;
        q.push_back(ex);
    endtask

    task automatic check_reset(input string tag);
        n_vec++;
        if (rom_code !== '0 || glyph_row !== '0 || glyph_col !== '0 ||
            fg_rgb !== '0 || fg_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: code=%h row=%h col=%h rgb=%h vld=%b expected all zero",
                     tag, rom_code, glyph_row, glyph_col, fg_rgb, fg_valid);
        end
    endtask

    // Monitor: each item matures at the edge after it was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t ex;
                ex = q.pop_front();
                n_vec++;
                if (rom_code !== ex.code || glyph_row !== ex.row || glyph_col !== ex.col ||
                    fg_rgb !== ex.rgb || fg_valid !== ex.vld) begin
                    n_bad++;
                    $display("FAIL %s: got code=%h row=%0d col=%0d rgb=%b vld=%b expected code=%h row=%0d col=%0d rgb=%b vld=%b",
                             ex.tag, rom_code, glyph_row, glyph_col, fg_rgb, fg_valid,
                             ex.code, ex.row, ex.col, ex.rgb, ex.vld);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs cleared under reset
        repeat (3) @(negedge clk);
        check_reset("R1 power-up");
        @(negedge clk);
        rst = 1'b0;

        // R2: character code passes through; R3: colors 1/2 outside windows
        // row_ctl_a = {C1=101, C2=011, h=0, w=0}
        drive(1, 8'h41, 8'b101_011_00, 8'b110_001_00, 0, 0, 0, 5'd7, 4'd3, 1, "R3 color1");
        drive(1, 8'hC1, 8'b101_011_00, 8'b110_001_00, 0, 0, 0, 5'd7, 4'd3, 1, "R3 color2");
        drive(0, 8'h7F, 8'b101_011_00, 8'b110_001_00, 0, 0, 0, 5'd1, 4'd1, 1, "R2 code 7F");
        drive(1, 8'h00, 8'b101_011_00, 8'b110_001_00, 0, 0, 0, 5'd0, 4'd0, 0, "R2 code 00");

        // R4: window extra select widens to colors 3/4
        drive(1, 8'h12, 8'b101_011_00, 8'b110_001_00, 1, 1, 1, 5'd4, 4'd2, 1, "R4 color3");
        drive(1, 8'h92, 8'b101_011_00, 8'b110_001_00, 1, 1, 1, 5'd4, 4'd2, 1, "R4 color4");

        // R5: any missing term keeps colors 1/2
        drive(1, 8'h92, 8'b101_011_00, 8'b110_001_00, 1, 0, 1, 5'd4, 4'd2, 1, "R5 window disabled");
        drive(1, 8'h12, 8'b101_011_00, 8'b110_001_00, 1, 1, 0, 5'd4, 4'd2, 1, "R5 no extra select");
        drive(1, 8'h92, 8'b101_011_00, 8'b110_001_00, 0, 1, 1, 5'd4, 4'd2, 1, "R5 outside window");

        // R6/R7: scaling flags, alone and combined
        drive(1, 8'h05, 8'b101_011_10, 8'h00, 0, 0, 0, 5'd13, 4'd9, 1, "R6 double height");
        drive(1, 8'h05, 8'b101_011_01, 8'h00, 0, 0, 0, 5'd13, 4'd9, 1, "R7 double width");
        drive(1, 8'h05, 8'b101_011_11, 8'h00, 0, 0, 0, 5'd31, 4'd15, 1, "R7 both flags max");
        drive(1, 8'h85, 8'b101_011_11, 8'b000_111_00, 1, 1, 1, 5'd30, 4'd14, 1, "R4 R6 window with doubling");

        // R8: gating
        drive(1, 8'hC1, 8'b111_111_00, 8'hFC, 1, 1, 1, 5'd2, 4'd2, 0, "R8 glyph bit clear");
        drive(0, 8'hC1, 8'b111_111_00, 8'hFC, 1, 1, 1, 5'd2, 4'd2, 1, "R8 outside active area");

        // Mixed stream against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r1, r2;
            r1 = $urandom;
            r2 = $urandom;
            drive(r1[0], r1[15:8], r1[23:16], r1[31:24], r2[0], r2[1], r2[2],
                  r2[8:4], r2[12:9], r2[13], "R3 R4 R5 R6 R7 R8 random");
        end

        // R1: reset in the middle of activity
        drive(1, 8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 5'd31, 4'd15, 1, "R2 before reset");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset("R1 mid-run");
        rst = 1'b0;
        drive(1, 8'h3C, 8'b010_100_00, 8'h00, 0, 0, 0, 5'd6, 4'd5, 1, "R3 after reset");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule